// File: doc/BRIEF.md
# Setpoint and Test Waveform Selector

This block decides, for one channel of a current-control loop, what drives the DAC and what is offered to the PI controller as its setpoint. When the loop is open, host-written DAC words and their start strobe pass straight through. When the loop is closed, the block can do one of three things: drive a triangle or square test wave directly into the DAC and bypass the controller, turn the controller setpoint into a square wave, or pass a static setpoint through.

Every waveform is derived from one period counter. The counter advances only on the ADC sample tick and wraps after a programmable maximum count. Each wave swings between two levels. The upper level is the channel setpoint word. The lower level is a separate limit word. A debug output always mirrors the setpoint currently given to the controller. All outputs are registered and change one clock after the inputs that select them.

Top module: `sp_wave_sel`

## Requirements
- R1: With `pi_en`=0, `dac_data` and `dac_start` equal `ol_data` and `ol_start` of the previous clock.
- R2: With `pi_en`=1 and either wave enable set, `dac_start` equals `tick` of the previous clock. If `tri_en` and `sqr_en` are both 1, the triangle wave is used.
- R3: In square mode (`pi_en`=1, `tri_en`=0, `sqr_en`=1), `dac_data` is `sp_hi` while the counter value c < (M+1)/2 (integer division, M = `period_max`) and is `lim_lo` otherwise.
- R4: In triangle mode, `dac_data` = lo + floor((hi-lo)*r/h), where h=(M+1)/2 and r = c when c<h, otherwise M+1-c, clamped to at most h. If c > M, r = 0. If hi <= lo, `dac_data` = hi.
- R5: The counter starts at 0 after reset and changes only on a clock with `tick`=1. On such a clock it becomes 0 if c >= M, and c+1 otherwise.
- R6: With `period_max`=0, both waves stay at `sp_hi`.
- R7: `pi_sp` is the square wave of R3 when `pi_en`=1, both DAC wave enables are 0 and `sp_sqr_en`=1. In every other case it is `sp_hi`.
- R8: `dbg_sp` always equals `pi_sp`.
- R9: With `pi_en`=1 and both DAC wave enables at 0, `dac_start` is 0 and `dac_data` keeps its last value.
- R10: During reset, `dac_data`, `dac_start`, `pi_sp` and `dbg_sp` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | ADC sample tick |
| pi_en | input | 1 | Closed-loop enable |
| tri_en | input | 1 | Triangle wave to DAC |
| sqr_en | input | 1 | Square wave to DAC |
| sp_sqr_en | input | 1 | Square wave on setpoint |
| sp_hi | input | 16 | Setpoint and upper level |
| lim_lo | input | 16 | Lower level |
| period_max | input | 22 | Maximum count of the period counter |
| ol_data | input | 16 | Open-loop DAC word |
| ol_start | input | 1 | Open-loop DAC start strobe |
| dac_data | output | 16 | DAC word |
| dac_start | output | 1 | DAC start strobe |
| pi_sp | output | 16 | Setpoint to the PI controller |
| dbg_sp | output | 16 | Debug copy of the setpoint |

## Verification
The in-line assertions check the following on every cycle:
- open-loop pass-through;
- the start strobe in wave modes and its absence in closed-loop setpoint modes;
- that square outputs take only one of the two levels;
- that the triangle never goes past its limits;
- that the counter holds between ticks and wraps at the maximum;
- the zero-period hold and the static setpoint path.

Only the bench scenarios can show the exact ramp values along a period, the position of the square-wave edges, and the triangle-over-square priority. The same applies to the hold of the DAC word when control passes to the controller and to the behaviour after the period or the limits change during a run.

// File: rtl/sp_wave_sel.sv
module sp_wave_sel #(
  parameter int DW = 16,
  parameter int CW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          pi_en,
  input  logic          tri_en,
  input  logic          sqr_en,
  input  logic          sp_sqr_en,
  input  logic [DW-1:0] sp_hi,
  input  logic [DW-1:0] lim_lo,
  input  logic [CW-1:0] period_max,
  input  logic [DW-1:0] ol_data,
  input  logic          ol_start,
  output logic [DW-1:0] dac_data,
  output logic          dac_start,
  output logic [DW-1:0] pi_sp,
  output logic [DW-1:0] dbg_sp
);
  localparam int PW = DW + CW + 1;

  logic [CW-1:0] cnt;
  logic [CW:0]   len, half, half_nz, cx, r_raw, r_c;
  logic          zero_max, first_half, in_range;
  logic [DW-1:0] span, tri_val, tri_w, sq_w;
  logic [PW-1:0] prod, quot;

  assign zero_max   = (period_max == '0);
  assign len        = {1'b0, period_max} + {{CW{1'b0}}, 1'b1};
  assign half       = len >> 1;
  assign half_nz    = zero_max ? {{CW{1'b0}}, 1'b1} : half;
  assign cx         = {1'b0, cnt};
  assign first_half = cx < half;
  assign in_range   = cx < len;

  assign sq_w = (zero_max || first_half) ? sp_hi : lim_lo;

  assign r_raw   = !in_range ? '0 : (first_half ? cx : len - cx);
  assign r_c     = (r_raw > half) ? half : r_raw;
  assign span    = sp_hi - lim_lo;
  assign prod    = {{(CW+1){1'b0}}, span} * {{DW{1'b0}}, r_c};
  assign quot    = prod / {{DW{1'b0}}, half_nz};
  assign tri_val = lim_lo + quot[DW-1:0];
  assign tri_w   = (zero_max || sp_hi <= lim_lo || tri_val > sp_hi) ? sp_hi : tri_val;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (tick)
      cnt <= (cnt >= period_max) ? '0 : cnt + {{(CW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_data  <= '0;
      dac_start <= 1'b0;
      pi_sp     <= '0;
    end else begin
      if (!pi_en) begin
        dac_data  <= ol_data;
        dac_start <= ol_start;
      end else if (tri_en) begin
        dac_data  <= tri_w;
        dac_start <= tick;
      end else if (sqr_en) begin
        dac_data  <= sq_w;
        dac_start <= tick;
      end else begin
        dac_start <= 1'b0;
      end
      pi_sp <= (pi_en && !tri_en && !sqr_en && sp_sqr_en) ? sq_w : sp_hi;
    end
  end

  assign dbg_sp = pi_sp;

  p_open_loop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pi_en |=> (dac_data == $past(ol_data) && dac_start == $past(ol_start)));

  p_wave_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pi_en && (tri_en || sqr_en)) |=> dac_start == $past(tick));

  p_sq_levels_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pi_en && !tri_en && sqr_en) |=>
      (dac_data == $past(sp_hi) || dac_data == $past(lim_lo)));

  p_tri_bounds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pi_en && tri_en && sp_hi >= lim_lo) |=>
      (dac_data <= $past(sp_hi) && dac_data >= $past(lim_lo)));

  p_tick_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  p_cnt_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cnt >= period_max) |=> cnt == '0);

  p_zero_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pi_en && (tri_en || sqr_en) && period_max == '0) |=> dac_data == $past(sp_hi));

  p_static_sp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pi_en && !tri_en && !sqr_en && sp_sqr_en) |=> pi_sp == $past(sp_hi));

  p_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pi_en && !tri_en && !sqr_en) |=> (!dac_start && $stable(dac_data)));
endmodule

// File: tb/sp_wave_sel_test.sv
module sp_wave_sel_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, pi_en = 0, tri_en = 0, sqr_en = 0, sp_sqr_en = 0, ol_start = 0;
  logic [15:0] sp_hi = 0, lim_lo = 0, ol_data = 0;
  logic [21:0] period_max = 0;
  logic [15:0] dac_data, pi_sp, dbg_sp;
  logic dac_start;

  int errors = 0, checks = 0;
  int cnt_m = 0;
  logic [15:0] e_dac = 0, e_sp = 0;
  logic e_st = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sp_wave_sel uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pi_en(pi_en), .tri_en(tri_en),
    .sqr_en(sqr_en), .sp_sqr_en(sp_sqr_en), .sp_hi(sp_hi), .lim_lo(lim_lo),
    .period_max(period_max), .ol_data(ol_data), .ol_start(ol_start),
    .dac_data(dac_data), .dac_start(dac_start), .pi_sp(pi_sp), .dbg_sp(dbg_sp));

  function automatic logic [15:0] m_sq(int c, int mx, logic [15:0] hi, logic [15:0] lo);
    if (mx == 0) return hi;
    return (c < (mx + 1) / 2) ? hi : lo;
  endfunction

  function automatic logic [15:0] m_tri(int c, int mx, logic [15:0] hi, logic [15:0] lo);
    longint len, h, r;
    if (mx == 0 || hi <= lo) return hi;
    len = mx + 1;
    h = len / 2;
    if (c >= len) r = 0;
    else r = (c < h) ? c : len - c;
    if (r > h) r = h;
    return 16'(longint'(lo) + ((longint'(hi) - longint'(lo)) * r) / h);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag);
    string dtag, stag;
    @(posedge clk);
    if (!pi_en) begin
      e_dac = ol_data; e_st = ol_start; dtag = "R1";
    end else if (tri_en) begin
      e_dac = m_tri(cnt_m, int'(period_max), sp_hi, lim_lo); e_st = tick; dtag = "R4";
    end else if (sqr_en) begin
      e_dac = m_sq(cnt_m, int'(period_max), sp_hi, lim_lo); e_st = tick; dtag = "R3";
    end else begin
      e_st = 0; dtag = "R9";
    end
    if (pi_en && !tri_en && !sqr_en && sp_sqr_en) begin
      e_sp = m_sq(cnt_m, int'(period_max), sp_hi, lim_lo); stag = "R7 square";
    end else begin
      e_sp = sp_hi; stag = "R7 static";
    end
    if (tick) cnt_m = (cnt_m >= int'(period_max)) ? 0 : cnt_m + 1;
    if (tag != "") dtag = tag;
    @(negedge clk);
    check({dtag, " dac_data"}, dac_data, e_dac);
    check((pi_en && (tri_en || sqr_en)) ? "R2 dac_start" : {dtag, " dac_start"}, dac_start, e_st);
    check(stag, pi_sp, e_sp);
    check("R8 dbg_sp", dbg_sp, pi_sp);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(20240611);
    ol_data = 16'h1234; ol_start = 1; sp_hi = 16'h4444;
    repeat (3) @(negedge clk);
    check("R10 dac_data", dac_data, 0);
    check("R10 dac_start", dac_start, 0);
    check("R10 pi_sp", pi_sp, 0);
    check("R10 dbg_sp", dbg_sp, 0);
    rst_n = 1; cnt_m = 0;

    step("R1");
    pi_en = 1; tri_en = 1; sqr_en = 1; sp_hi = 1000; lim_lo = 200; period_max = 7;
    for (int i = 0; i < 20; i++) begin tick = 1; step("R2"); end
    tri_en = 0; period_max = 3; tick = 0;
    for (int i = 0; i < 4; i++) step("R5");
    tick = 1;
    for (int i = 0; i < 10; i++) step("R5");
    period_max = 0;
    for (int i = 0; i < 5; i++) step("R6");
    sqr_en = 0; tri_en = 1;
    for (int i = 0; i < 5; i++) step("R6");
    period_max = 9; sp_hi = 100; lim_lo = 900;
    for (int i = 0; i < 12; i++) step("R4");
    tri_en = 0; sqr_en = 0; sp_sqr_en = 1; sp_hi = 3000; lim_lo = 10;
    for (int i = 0; i < 12; i++) step("");

    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 40 == 0) begin
        sp_hi = 16'($urandom);
        lim_lo = ($urandom % 8 == 0) ? 16'($urandom) : 16'($urandom % (int'(sp_hi) + 1));
      end
      if ($urandom % 60 == 0) period_max = 22'($urandom % 25);
      if ($urandom % 30 == 0) begin
        pi_en = ($urandom % 5) != 0;
        tri_en = ($urandom % 3) == 0;
        sqr_en = ($urandom % 3) == 0;
        sp_sqr_en = ($urandom % 2) == 0;
      end
      tick = ($urandom % 3) != 0;
      ol_data = 16'($urandom);
      ol_start = $urandom % 2;
      step("");
    end
    period_max = 22'h3FFFFF; pi_en = 1; tri_en = 1; sp_hi = 16'hFFFF; lim_lo = 0; tick = 1;
    for (int i = 0; i < 8; i++) step("R4");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule